// File: doc/BRIEF.md
# Fractional Serial Baud Rate Generator

This block makes the bit-rate timing for one serial channel. Four prescaler tick inputs arrive from a shared prescaler. They run at 1/1, 1/4, 1/16 and 1/64 of a system tick. A 2-bit select picks one of them, and that tick drives a programmable divider.

The divider has two modes. In integer mode it divides by N. In fractional mode it mixes N-tick and (N+1)-tick periods so that the average ratio is N + (16−K)/16. Each divider period ends with a one-cycle divider tick. A final stage then counts divider ticks and issues a one-cycle baud tick. In asynchronous (UART) operation the baud tick comes once every 16 divider ticks. In synchronous shift operation it comes once every 2 divider ticks.

All timing is carried as enable pulses in the system clock domain, and the block derives no clocks. Register access, the prescaler itself and the shifters sit outside the block. The divider settings arrive as plain input ports.

Top module: `frac_baud_gen`

## Requirements
- R1: `tap_sel` value s picks `tap_in[s]`, with 0 selecting divide-by-1, 1 divide-by-4, 2 divide-by-16 and 3 divide-by-64. Only ticks on the selected tap advance the divider.
- R2: In integer mode, each divider period is exactly N selected ticks. `div_n` = 0 means N = 16, and `div_n` = 1..15 means N = `div_n`. `frac_k` has no effect in this mode.
- R3: In fractional mode, each divider period is N or N+1 selected ticks. Any 16 consecutive periods together last 16·N + (16−`frac_k`) selected ticks.
- R4: In fractional mode with `frac_k` ≥ 8, no two consecutive divider periods are both N+1 ticks long.
- R5: When `div_n` is 0 or 1, the block runs in integer mode even if `frac_en` is 1.
- R6: When `sync_mode` is 1, the block runs in integer mode even if `frac_en` is 1.
- R7: With `sync_mode` = 0, `baud_tick` pulses once every 16 divider ticks, and always in the same cycle as a `div_tick`.
- R8: With `sync_mode` = 1, `baud_tick` pulses once every 2 divider ticks.
- R9: A change to any setting input clears all counters on the next clock. With the divide-by-1 tap, the first `div_tick` after the change appears N+1 cycles after it.
- R10: While `run` is 0, both outputs stay low and all counters are held at 0. With the divide-by-1 tap, the first `div_tick` after `run` returns to 1 appears N cycles later. In UART operation the first `baud_tick` appears 16 divider ticks later.
- R11: While `rst_n` is 0 (synchronous reset), both outputs are low on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Enables counting; 0 holds everything cleared |
| tap_in | input | 4 | Prescaler tick enables: bit0 /1, bit1 /4, bit2 /16, bit3 /64 |
| tap_sel | input | 2 | Selects which tap drives the divider |
| div_n | input | NW | Integer divisor N (0 encodes 16) |
| frac_k | input | NW | Fractional term K |
| frac_en | input | 1 | Requests fractional mode |
| sync_mode | input | 1 | 1 = synchronous shift (final /2), 0 = UART (final /16) |
| div_tick | output | 1 | One-cycle pulse at the end of each divider period |
| baud_tick | output | 1 | One-cycle pulse per final baud period |

## Verification
The bench measures the spans between ticks for both modes and all four taps. It checks that the long periods sum to exactly 16−K per 16 periods, and that they never bunch when K is 8 or more. A design with an off-by-one in the overflow test, or one that keeps fractional mode on when N is 1 or 16 or in synchronous mode, would produce a wrong 16-period span. The restart tests check the exact cycle of the first tick after a setting change and after `run` returns. A design that failed to clear, or that cleared one cycle late, would land one cycle off. A K-ignored vector and a divide-by-64 synchronous vector catch a divider that leaks the fractional term or selects the wrong tap.

// File: rtl/frac_baud_gen.sv
module frac_baud_gen #(
  parameter int NW  = 4,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [3:0]    tap_in,
  input  logic [1:0]    tap_sel,
  input  logic [NW-1:0] div_n,
  input  logic [NW-1:0] frac_k,
  input  logic          frac_en,
  input  logic          sync_mode,
  output logic          div_tick,
  output logic          baud_tick
);
  localparam int CW = NW + 1;
  localparam int OW = $clog2(OVS);
  localparam int GW = 2 + 2*NW + 2;

  logic [CW-1:0] cnt;
  logic [NW-1:0] phase;
  logic [OW-1:0] fcnt;
  logic [GW-1:0] cfg, cfg_q;

  // R2: zero encodes the top divisor
  wire [CW-1:0] n_eff    = (div_n == '0) ? CW'(1 << NW) : {1'b0, div_n};
  // R5, R6: fractional mode only when legal
  wire          frac_on  = frac_en && !sync_mode && (div_n > NW'(1));
  // R3: phase accumulates 16-K per period; overflow marks a long period
  wire [CW-1:0] step     = CW'(1 << NW) - {1'b0, frac_k};
  wire [CW-1:0] acc      = {1'b0, phase} + step;
  wire          long_per = frac_on && acc[NW];
  wire [CW-1:0] last     = n_eff + CW'(long_per) - CW'(1);

  wire          tick     = tap_in[tap_sel];
  wire          div_ev   = tick && (cnt == last);
  wire [OW-1:0] flast    = sync_mode ? OW'(1) : OW'(OVS - 1);
  wire          restart  = !run || (cfg != cfg_q);

  assign cfg = {tap_sel, div_n, frac_k, frac_en, sync_mode};

  always_ff @(posedge clk) begin
    cfg_q <= cfg;
    if (!rst_n || restart) begin
      cnt       <= '0;
      phase     <= '0;
      fcnt      <= '0;
      div_tick  <= 1'b0;
      baud_tick <= 1'b0;
    end else begin
      div_tick  <= div_ev;
      baud_tick <= div_ev && (fcnt == flast);
      if (tick) cnt <= div_ev ? '0 : cnt + 1'b1;
      if (div_ev) begin
        if (frac_on) phase <= acc[NW-1:0];
        fcnt <= (fcnt == flast) ? '0 : fcnt + 1'b1;
      end
    end
  end

  a_r7_baud_on_div: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick |-> div_tick);
  a_r10_run_low_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!div_tick && !baud_tick));
  a_r9_change_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg != cfg_q) |=> !div_tick);
  a_r3_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(1 << NW));
  a_r8_sync_final: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_mode && cfg == cfg_q) |-> (fcnt <= OW'(1)));
  a_r11_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!div_tick && !baud_tick));
endmodule

// File: tb/frac_baud_gen_bench.sv
`timescale 1ns/1ps
module frac_baud_gen_bench;
  logic       clk = 1'b0, rst_n = 1'b0, run = 1'b1;
  logic [3:0] tap_in;
  logic [1:0] tap_sel = 2'd0;
  logic [3:0] div_n = 4'd1, frac_k = 4'd0;
  logic       frac_en = 1'b0, sync_mode = 1'b0;
  logic       div_tick, baud_tick;
  int errors = 0, checks = 0, cyc = 0, tc = 0;
  bit done = 0;

  frac_baud_gen u_frac_baud_gen (
    .clk(clk), .rst_n(rst_n), .run(run), .tap_in(tap_in), .tap_sel(tap_sel),
    .div_n(div_n), .frac_k(frac_k), .frac_en(frac_en), .sync_mode(sync_mode),
    .div_tick(div_tick), .baud_tick(baud_tick)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) tc <= tc + 1;
  assign tap_in = {(tc % 64) == 0, (tc % 16) == 0, (tc % 4) == 0, 1'b1};

  // {tap_sel, div_n, frac_k, frac_en, sync_mode, cycles spanned by 16 divider ticks}
  localparam int NV = 10;
  localparam logic [27:0] VEC [NV] = '{
    {2'd0, 4'd5,  4'd0,  1'b0, 1'b0, 16'd80},   // R2
    {2'd0, 4'd5,  4'd3,  1'b1, 1'b0, 16'd93},   // R3
    {2'd1, 4'd3,  4'd8,  1'b1, 1'b0, 16'd224},  // R1 R3 R4
    {2'd0, 4'd0,  4'd5,  1'b1, 1'b0, 16'd256},  // R5 (N=16)
    {2'd0, 4'd1,  4'd7,  1'b1, 1'b1, 16'd16},   // R5 R8
    {2'd0, 4'd7,  4'd4,  1'b1, 1'b1, 16'd112},  // R6 R8
    {2'd2, 4'd2,  4'd15, 1'b1, 1'b0, 16'd528},  // R1 R3 R4
    {2'd3, 4'd2,  4'd1,  1'b0, 1'b1, 16'd2048}, // R1 R2 R8
    {2'd0, 4'd15, 4'd1,  1'b1, 1'b0, 16'd255},  // R3
    {2'd0, 4'd4,  4'd15, 1'b0, 1'b0, 16'd64}    // R2 K ignored
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic next_div(output int t);
    do @(negedge clk); while (!div_tick);
    t = cyc;
  endtask

  task automatic next_baud(output int t);
    do @(negedge clk); while (!baud_tick);
    t = cyc;
  endtask

  task automatic first_hit(input bit use_baud, input int lim, output int idx);
    idx = -1;
    for (int i = 1; i <= lim; i++) begin
      @(negedge clk);
      if (idx < 0 && (use_baud ? baud_tick : div_tick)) idx = i;
    end
  endtask

  initial begin
    logic [1:0] s; logic [3:0] n, k; logic fe, sy; logic [15:0] tot;
    int per, neff, t0, tp, t, d, bad, adj, b0, b1, idx, cnt0;
    bit feff, islong, prevlong;
    string rq;

    // R11: reset holds outputs low even with a tick every cycle
    cnt0 = 0;
    repeat (6) begin @(negedge clk); cnt0 += div_tick + baud_tick; end
    chk("R11 outputs during reset", cnt0, 0);
    @(negedge clk); rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      {s, n, k, fe, sy, tot} = VEC[v];
      @(negedge clk);
      tap_sel = s; div_n = n; frac_k = k; frac_en = fe; sync_mode = sy;
      per  = 1 << (2 * s);
      neff = (n == 0) ? 16 : n;
      feff = fe && !sy && n > 1;
      rq   = feff ? "R3" : "R2";
      next_div(t0); tp = t0; bad = 0; adj = 0; prevlong = 0;
      for (int i = 0; i < 16; i++) begin
        next_div(t); d = t - tp; tp = t;
        islong = feff && (d == per * (neff + 1));
        if (d != per * neff && !islong) bad++;
        if (islong && prevlong) adj++;
        prevlong = islong;
      end
      chk({rq, " period length"}, bad, 0);
      chk({rq, " 16-period span (R1 R5 R6 tap/mode)"}, t - t0, tot);
      if (feff && k >= 8) chk("R4 long periods adjacent", adj, 0);
      next_baud(b0); b1 = b0;
      for (int i = 0; i < (sy ? 8 : 1); i++) next_baud(b1);
      chk(sy ? "R8 sync baud span" : "R7 uart baud span", b1 - b0, tot);
    end

    // R9: setting change restarts the divider
    @(negedge clk); tap_sel = 0; div_n = 5; frac_en = 0; sync_mode = 0;
    repeat (13) @(negedge clk);
    div_n = 6;
    first_hit(1'b0, 10, idx);
    chk("R9 first div tick after change", idx, 7);

    // R10: run low silences and clears; restart timing
    @(negedge clk); run = 1'b0;
    cnt0 = 0;
    repeat (20) begin @(negedge clk); cnt0 += div_tick + baud_tick; end
    chk("R10 outputs while run low", cnt0, 0);
    run = 1'b1;
    first_hit(1'b0, 10, idx);
    chk("R10 first div tick after run", idx, 6);

    @(negedge clk); div_n = 1;
    repeat (5) @(negedge clk);
    run = 1'b0;
    repeat (2) @(negedge clk);
    run = 1'b1;
    first_hit(1'b1, 20, idx);
    chk("R10 first baud tick after run", idx, 16);

    // R11: reset mid-run
    @(negedge clk); rst_n = 1'b0;
    cnt0 = 0;
    repeat (4) begin @(negedge clk); cnt0 += div_tick; end
    chk("R11 outputs after mid-run reset", cnt0, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 190000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule